// File: doc/BRIEF.md
# Power-of-Two Tap Timer with LCD Clock Divider

This block is a 16-bit free-running up-counter that advances once per pulse of one of four enable strobes. The strobes stand in for the clock sources: an external sub-clock, a prescaler output, a fast internal oscillator and a slow internal oscillator. A 3-bit tap code picks a period of 2^(9+k) counts, from 512 to 65536. When the low 9+k bits roll over to zero, the block raises a one-cycle interrupt pulse. A second strobe marks each wrap of the whole 16-bit counter, for use by downstream counters.

A 4-bit reloadable down counter builds the LCD clock. It is clocked either by the rising transition of counter bit 4 or by every system clock. On each underflow it reloads and toggles the LCD clock, so a reload value N divides its source by N+1.

A small control machine owns the tap code. After reset it passes through LOAD, which copies the tap input once. It then sits in RUN. A tap input that differs from the active tap moves it to PEND (RUN→PEND). In PEND the old tap keeps running. When the old tap rolls over, the new code is adopted, the counter is cleared and the machine returns to RUN (PEND→RUN, adopt). If the tap input returns to the active value first, the machine goes back to RUN with no change (PEND→RUN, cancel).

Top module: `pow2_tap_timer`

## Requirements
- R1: After reset, irq_o, udf_o and lcd_clk_o are 0.
- R2: The counter advances only in cycles where src_en_i[src_sel_i] is 1; src_sel_i values 0..3 select strobe bits 0..3. With the selected strobe held low, no interrupt is produced and, with lc_src_sel_i=0, lcd_clk_o holds.
- R3: With tap code k active and the selected strobe high every cycle, irq_o pulses every 2^(9+k) cycles (k=0 gives 512, k=3 gives 4096, k=7 gives 65536).
- R4: irq_o is high for exactly one cycle per rollover.
- R5: A new tap code does not cut the running period short: the rollover of the old tap still ends the period at its full length and raises the interrupt.
- R6: After the new code is adopted, the counter restarts from zero, so the first new period has its full length. A code that returns to the active value before the rollover causes no change.
- R7: udf_o pulses in the cycle after the counter passes from 0xFFFF to 0. Every such pulse coincides with an irq_o pulse.
- R8: With lc_src_sel_i=1, the LCD divider counts every clock, and lcd_clk_o toggles every lc_reload_i+1 cycles.
- R9: With lc_src_sel_i=0, the LCD divider counts once per rising edge of counter bit 4, which is once every 32 counter ticks. With reload N, lcd_clk_o toggles every 32*(N+1) ticks.
- R10: A reload value of 0 makes lcd_clk_o toggle on every divider count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en_i | input | 4 | One enable strobe per count source |
| src_sel_i | input | 2 | Index of the strobe that advances the counter |
| tap_sel_i | input | 3 | Tap code k; period is 2^(9+k) |
| lc_reload_i | input | 4 | LCD divider reload value N (divides by N+1) |
| lc_src_sel_i | input | 1 | 0: counter bit 4 rising edge, 1: every system clock |
| irq_o | output | 1 | One-cycle interrupt at each tap rollover |
| udf_o | output | 1 | One-cycle strobe at each full 16-bit wrap |
| lcd_clk_o | output | 1 | LCD clock, toggles at each divider underflow |

## Verification
The bench changes the tap in the middle of a period. A design that switched at once would fire early or skip the interrupt, and one that did not clear the counter would make the first new period short. It also changes the tap and then restores it before the rollover; a design that adopted the transient code would change the period. Other cases cover a stalled source, which must freeze both the interrupt and the bit-4-driven LCD divider, and reload value 0, which an off-by-one divider would turn into a 16-count period. The bench also runs one full 65536-count period, where the wrap strobe has to line up with the interrupt.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } tap_state_e;
endpackage

// File: rtl/tap_src_mux.sv
module tap_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = src_en[i];
        end
    end
endmodule

// File: rtl/tap_counter.sv
module tap_counter
    import tap_timer_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TAP_BASE  = 9,
    parameter int TAP_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [TAP_SEL_W-1:0] tap_sel,
    output logic                 irq,
    output logic                 udf,
    output logic [CNT_W-1:0]     count_o,
    output logic [TAP_SEL_W-1:0] active_tap_o,
    output tap_state_e           state_o
);
    localparam int NUM_TAPS = 1 << TAP_SEL_W;

    tap_state_e           state_q, state_d;
    logic [CNT_W-1:0]     count_q, count_d;
    logic [TAP_SEL_W-1:0] active_q, active_d;
    logic [NUM_TAPS-1:0]  tap_full;
    logic                 event_now, wrap_now, differs;

    // Low field of each tap is all ones: the next tick rolls it to zero
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign tap_full[k] = &count_q[TAP_BASE+k-1:0];
    end

    assign event_now = tick & tap_full[active_q];
    assign wrap_now  = tick & (&count_q);
    assign differs   = (tap_sel != active_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  if (differs) state_d = ST_PEND;
            ST_PEND: if (!differs || event_now) state_d = ST_RUN;
            default: state_d = ST_LOAD;
        endcase
    end

    // Data-path outputs of the machine
    always_comb begin
        count_d  = count_q + CNT_W'(tick);
        active_d = active_q;
        unique case (state_q)
            ST_LOAD: active_d = tap_sel;
            ST_PEND: begin
                if (differs && event_now) begin
                    active_d = tap_sel;
                    count_d  = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            active_q <= '0;
            irq      <= 1'b0;
            udf      <= 1'b0;
        end else begin
            count_q  <= count_d;
            active_q <= active_d;
            irq      <= event_now;
            udf      <= wrap_now;
        end
    end

    assign count_o      = count_q;
    assign active_tap_o = active_q;
    assign state_o      = state_q;
endmodule

// File: rtl/lc_divider.sv
module lc_divider #(
    parameter int LC_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_sys,
    input  logic            tap_bit,
    input  logic [LC_W-1:0] reload,
    output logic            lcd_clk
);
    logic            bit_q, lc_tick;
    logic [LC_W-1:0] cnt_q;

    assign lc_tick = src_sys | (tap_bit & ~bit_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= 1'b0;
            cnt_q   <= '0;
            lcd_clk <= 1'b0;
        end else begin
            bit_q <= tap_bit;
            if (lc_tick) begin
                if (cnt_q == '0) begin
                    cnt_q   <= reload;
                    lcd_clk <= ~lcd_clk;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pow2_tap_timer.sv
module pow2_tap_timer
    import tap_timer_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int TAP_SEL_W = 3,
    parameter int TAP_BASE  = 9,
    parameter int LC_W      = 4,
    parameter int LC_BIT    = 4,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int CNT_W    = TAP_BASE + (1 << TAP_SEL_W) - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_en_i,
    input  logic [SRC_W-1:0]     src_sel_i,
    input  logic [TAP_SEL_W-1:0] tap_sel_i,
    input  logic [LC_W-1:0]      lc_reload_i,
    input  logic                 lc_src_sel_i,
    output logic                 irq_o,
    output logic                 udf_o,
    output logic                 lcd_clk_o
);
    logic                 tick;
    logic [CNT_W-1:0]     count;
    logic [TAP_SEL_W-1:0] active_tap;
    tap_state_e           state;

    tap_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SRC_W)) u_mux (
        .src_en (src_en_i),
        .sel    (src_sel_i),
        .tick   (tick)
    );

    tap_counter #(.CNT_W(CNT_W), .TAP_BASE(TAP_BASE), .TAP_SEL_W(TAP_SEL_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .tap_sel      (tap_sel_i),
        .irq          (irq_o),
        .udf          (udf_o),
        .count_o      (count),
        .active_tap_o (active_tap),
        .state_o      (state)
    );

    lc_divider #(.LC_W(LC_W)) u_lc (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sys (lc_src_sel_i),
        .tap_bit (count[LC_BIT]),
        .reload  (lc_reload_i),
        .lcd_clk (lcd_clk_o)
    );
endmodule

// File: rtl/tap_timer_checker.sv
module tap_timer_checker
    import tap_timer_pkg::*;
#(
    parameter int NUM_SRC   = 4,
    parameter int SRC_W     = 2,
    parameter int TAP_SEL_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_en_i,
    input logic [SRC_W-1:0]     src_sel_i,
    input logic                 irq_o,
    input logic                 udf_o,
    input logic                 lcd_clk_o,
    input logic [TAP_SEL_W-1:0] active_tap,
    input tap_state_e           state
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !udf_o && !lcd_clk_o));

    a_r2_no_tick_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en_i[src_sel_i] |=> !irq_o);

    a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r5_tap_moves_on_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_LOAD && !$stable(active_tap)) |-> irq_o);

    a_r7_wrap_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        udf_o |-> irq_o);
endmodule

bind pow2_tap_timer tap_timer_checker #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .TAP_SEL_W(TAP_SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en_i   (src_en_i),
    .src_sel_i  (src_sel_i),
    .irq_o      (irq_o),
    .udf_o      (udf_o),
    .lcd_clk_o  (lcd_clk_o),
    .active_tap (active_tap),
    .state      (state)
);

// File: tb/pow2_tap_timer_bench.sv
`timescale 1ns/1ps
module pow2_tap_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_en = 4'hF;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] tap_sel = 3'd0;
    logic [3:0] lc_reload = 4'd5;
    logic       lc_src = 1'b1;
    logic       irq, udf, lcd;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pow2_tap_timer u_pow2_tap_timer (
        .clk(clk), .rst_n(rst_n), .src_en_i(src_en), .src_sel_i(src_sel),
        .tap_sel_i(tap_sel), .lc_reload_i(lc_reload), .lc_src_sel_i(lc_src),
        .irq_o(irq), .udf_o(udf), .lcd_clk_o(lcd)
    );

    // Behavioural reference model
    int m_cnt, m_tap, m_lc;
    bit m_loaded, m_pend, m_irq, m_udf, m_b4q, m_lcd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tap = 0; m_lc = 0;
            m_loaded = 0; m_pend = 0; m_irq = 0; m_udf = 0; m_b4q = 0; m_lcd = 0;
        end else begin
            bit tk, ev, lt, b4;
            int period;
            tk = src_en[src_sel];
            period = 1 << (9 + m_tap);
            ev = tk && (((m_cnt + 1) % period) == 0);
            b4 = ((m_cnt >> 4) & 1) == 1;
            lt = lc_src || (b4 && !m_b4q);
            m_b4q = b4;
            if (lt) begin
                if (m_lc == 0) begin m_lc = int'(lc_reload); m_lcd = !m_lcd; end
                else m_lc = m_lc - 1;
            end
            m_irq = ev;
            m_udf = tk && (m_cnt == 65535);
            if (!m_loaded) begin
                m_tap = int'(tap_sel); m_loaded = 1;
                m_cnt = (m_cnt + int'(tk)) % 65536;
            end else if (m_pend && ev && int'(tap_sel) != m_tap) begin
                m_tap = int'(tap_sel); m_cnt = 0; m_pend = 0;
            end else begin
                m_cnt = (m_cnt + int'(tk)) % 65536;
                m_pend = (int'(tap_sel) != m_tap);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq || udf !== m_udf || lcd !== m_lcd) begin
                fails++;
                $display("FAIL R3 R7 R8 model cycle %0d: got irq=%b udf=%b lcd=%b expected %b %b %b",
                         cycles, irq, udf, lcd, m_irq, m_udf, m_lcd);
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic sync_irq();
        do @(negedge clk); while (irq !== 1'b1);
    endtask

    task automatic irq_gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (irq !== 1'b1);
    endtask

    task automatic lcd_gap(output int n);
        logic prev;
        prev = lcd;
        n = 0;
        do begin @(negedge clk); n++; end while (lcd === prev);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", int'(irq), 0);
        check("R1 udf after reset", int'(udf), 0);

        // R8: system-clock source, reload 5
        lcd_gap(g); lcd_gap(g);
        check("R8 lcd half period reload 5", g, 6);
        // R10: reload 0
        lc_reload = 4'd0;
        lcd_gap(g); lcd_gap(g);
        check("R10 lcd half period reload 0", g, 1);
        // R9: bit-4 source, reload 2
        lc_src = 1'b0; lc_reload = 4'd2;
        lcd_gap(g); lcd_gap(g); lcd_gap(g);
        check("R9 lcd half period bit4 reload 2", g, 96);

        // R3 / R4: tap 0
        sync_irq();
        @(negedge clk);
        check("R4 irq single cycle", int'(irq), 0);
        irq_gap(g);
        check("R3 tap0 period", g + 1, 512);

        // R2: selected source stalled
        begin
            int seen;
            logic l0;
            seen = 0; l0 = lcd;
            src_sel = 2'd1; src_en = 4'b1101;
            repeat (1500) begin @(negedge clk); if (irq) seen++; end
            check("R2 no irq when stalled", seen, 0);
            check("R2 lcd holds when stalled", int'(lcd), int'(l0));
            src_en = 4'hF;
        end

        // R5 / R6: change tap mid period
        sync_irq();
        repeat (10) @(negedge clk);
        tap_sel = 3'd3;
        irq_gap(g);
        check("R5 old period completes", g + 10, 512);
        irq_gap(g);
        check("R6 first new period full", g, 4096);
        // R6: transient code is ignored
        repeat (100) @(negedge clk);
        tap_sel = 3'd1;
        repeat (100) @(negedge clk);
        tap_sel = 3'd3;
        irq_gap(g);
        check("R6 reverted code no change", g + 200, 4096);

        // R7: tap 7 full wrap
        repeat (5) @(negedge clk);
        tap_sel = 3'd7;
        irq_gap(g);
        check("R5 tap3 period before tap7", g + 5, 4096);
        irq_gap(g);
        check("R3 tap7 period", g, 65536);
        check("R7 udf with tap7 rollover", int'(udf), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule